// File: doc/BRIEF.md
# Nibble-Loaded DAC Code Register

This block sits between a narrow 4-bit processor data bus and a 12-bit digital-to-analogue converter. A full conversion code is too wide for the bus. Software therefore writes it a piece at a time. Three nibble writes, each steered by a two-bit register select, fill a 12-bit holding register. A fourth write, to the select value after the last nibble, ignores the data bus. That write copies the whole holding value into the output register in a single clock edge. The converter never sees a half-written code.

A write counts only in a clock cycle in which the active-low unit select and the active-low write strobe are both low. The address decoder outside the block drives the unit select, so each converter channel is a separate instance on its own address window. A separate active-low clear line, driven from a command decoder, zeroes the output register. It leaves the holding register alone. The nibble width and the nibble count are parameters. The select value that triggers the transfer always equals the nibble count.

Top module: `dwl_dac_front`

## Requirements
- R1: After reset, `code_o` reads 0 and the holding register is 0. A transfer write made before any nibble write therefore produces code 0.
- R2: A write with `reg_sel_i` = 0 loads `data_i` into holding bits 3:0 and leaves the other holding bits unchanged.
- R3: A write with `reg_sel_i` = 1 loads `data_i` into holding bits 7:4 and leaves the other holding bits unchanged.
- R4: A write with `reg_sel_i` = 2 loads `data_i` into holding bits 11:8 and leaves the other holding bits unchanged.
- R5: A write with `reg_sel_i` = 3 (transfer) places the holding value present before that edge on `code_o` after that edge. The value of `data_i` during a transfer has no effect on `code_o` or on the holding register.
- R6: In a cycle where `unit_sel_n` or `wr_n` is high, neither the holding register nor `code_o` changes, whatever `data_i` and `reg_sel_i` are.
- R7: A nibble write (`reg_sel_i` 0 to 2) never changes `code_o`.
- R8: A clock edge with `clr_n` low sets `code_o` to 0. This holds even when a transfer write happens in the same cycle.
- R9: A clear does not change the holding register. A later transfer write restores the code that was assembled before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_i | input | 4 | Nibble data from the bus |
| reg_sel_i | input | 2 | Register select: 0 low, 1 middle, 2 high nibble, 3 transfer |
| unit_sel_n | input | 1 | Active-low unit select from the address decoder |
| wr_n | input | 1 | Active-low write strobe |
| clr_n | input | 1 | Active-low clear of the output register |
| code_o | output | 12 | Code presented to the converter |

## Verification
The bench builds the block with its default parameters: a 4-bit nibble and three nibbles. That gives the 12-bit code and the 2-bit select of the requirements. In this build, all four select values decode to real operations, so random stimulus reaches every nibble position, every transfer and every gated-off write. Directed steps cover the transfer that collides with a clear, the transfer before any load, and the restoration of the code after a clear.

// File: rtl/dwl_pkg.sv
package dwl_pkg;
  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_NIB  = 2'd1,
    WK_XFER = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/dwl_rst_sync.sv
module dwl_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/dwl_hold_regs.sv
module dwl_hold_regs #(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 3,
  parameter int SEL_W   = 2,
  localparam int CODE_W = NIB_W * NUM_NIB
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [NIB_W-1:0]  data_i,
  output logic [CODE_W-1:0] hold_o
);
  for (genvar k = 0; k < NUM_NIB; k++) begin : g_nib
    logic [NIB_W-1:0] nib_q;
    logic [NIB_W-1:0] nib_d;
    logic             nib_en;

    always_comb begin
      nib_en = we_i && (sel_i == SEL_W'(k));
      nib_d  = nib_en ? data_i : nib_q;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) nib_q <= '0;
      else         nib_q <= nib_d;
    end

    assign hold_o[k*NIB_W +: NIB_W] = nib_q;

    AST_NIB_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
      (we_i && sel_i == SEL_W'(k)) |=> (hold_o[k*NIB_W +: NIB_W] == $past(data_i))); // R2 R3 R4
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !we_i |=> $stable(hold_o)); // R6
endmodule

// File: rtl/dwl_out_reg.sv
module dwl_out_reg #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              xfer_i,
  input  logic [CODE_W-1:0] hold_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    code_d = code_q;
    if (!clr_ni)     code_d = '0;
    else if (xfer_i) code_d = hold_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    !clr_ni |=> (code_o == '0)); // R8
  AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_ni)
    (xfer_i && clr_ni) |=> (code_o == $past(hold_i))); // R5
  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!xfer_i && clr_ni) |=> $stable(code_o)); // R7
endmodule

// File: rtl/dwl_dac_front.sv
module dwl_dac_front #(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 3,
  localparam int SEL_W  = $clog2(NUM_NIB + 1),
  localparam int CODE_W = NIB_W * NUM_NIB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  data_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic              unit_sel_n,
  input  logic              wr_n,
  input  logic              clr_n,
  output logic [CODE_W-1:0] code_o
);
  import dwl_pkg::*;

  logic              rst_int_n;
  wr_kind_e          wr_kind;
  logic [CODE_W-1:0] hold;

  dwl_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_int_n)
  );

  always_comb begin
    wr_kind = WK_NONE;
    if (!unit_sel_n && !wr_n) begin
      if (reg_sel_i == SEL_W'(NUM_NIB))     wr_kind = WK_XFER;
      else if (reg_sel_i < SEL_W'(NUM_NIB)) wr_kind = WK_NIB;
    end
  end

  dwl_hold_regs #(
    .NIB_W   (NIB_W),
    .NUM_NIB (NUM_NIB),
    .SEL_W   (SEL_W)
  ) u_hold (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .we_i   (wr_kind == WK_NIB),
    .sel_i  (reg_sel_i),
    .data_i (data_i),
    .hold_o (hold)
  );

  dwl_out_reg #(
    .CODE_W (CODE_W)
  ) u_out (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .clr_ni (clr_n),
    .xfer_i (wr_kind == WK_XFER),
    .hold_i (hold),
    .code_o (code_o)
  );

  AST_GATED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((unit_sel_n || wr_n) && clr_n) |=> $stable(code_o)); // R6
endmodule

// File: tb/sim_dwl_dac_front.sv
module sim_dwl_dac_front;
  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 1357;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  data_i;
  logic [1:0]  reg_sel_i;
  logic        unit_sel_n;
  logic        wr_n;
  logic        clr_n;
  logic [11:0] code_o;

  int checks = 0;
  int errors = 0;
  logic [11:0] m_hold = '0;
  logic [11:0] m_code = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwl_dac_front u0 (
    .clk(clk), .rst_n(rst_n), .data_i(data_i), .reg_sel_i(reg_sel_i),
    .unit_sel_n(unit_sel_n), .wr_n(wr_n), .clr_n(clr_n), .code_o(code_o)
  );

  function automatic logic [11:0] f_hold(logic [11:0] h, logic [3:0] d, logic [1:0] s,
                                         logic us, logic w);
    logic [11:0] r = h;
    if (!us && !w && s != 2'd3) r[s*4 +: 4] = d;
    return r;
  endfunction

  function automatic logic [11:0] f_code(logic [11:0] c, logic [11:0] h, logic [1:0] s,
                                         logic us, logic w, logic cl);
    if (!cl) return 12'd0;
    if (!us && !w && s == 2'd3) return h;
    return c;
  endfunction

  task automatic check(string req, logic [11:0] exp);
    checks++;
    if (code_o !== exp) begin
      errors++;
      $display("FAIL %s: code_o=%h expected=%h", req, code_o, exp);
    end
  endtask

  task automatic step(logic [3:0] d, logic [1:0] s, logic us, logic w, logic cl, string req);
    logic [11:0] nh;
    logic [11:0] nc;
    data_i = d; reg_sel_i = s; unit_sel_n = us; wr_n = w; clr_n = cl;
    nh = f_hold(m_hold, d, s, us, w);
    nc = f_code(m_code, m_hold, s, us, w, cl);
    @(posedge clk);
    m_hold = nh; m_code = nc;
    @(negedge clk);
    data_i = 4'h0; unit_sel_n = 1'b1; wr_n = 1'b1; clr_n = 1'b1;
    check(req, m_code);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: code_o=%h expected=done", code_o);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(SEED));
    rst_n = 1'b0; data_i = '0; reg_sel_i = '0; unit_sel_n = 1'b1; wr_n = 1'b1; clr_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 12'h000);
    step(4'hF, 2'd3, 1'b0, 1'b0, 1'b1, "R1");          // transfer before any load
    // directed assembly
    step(4'hA, 2'd0, 1'b0, 1'b0, 1'b1, "R2");
    step(4'h5, 2'd1, 1'b0, 1'b0, 1'b1, "R3");
    step(4'hC, 2'd2, 1'b0, 1'b0, 1'b1, "R4");
    step(4'h0, 2'd3, 1'b0, 1'b0, 1'b1, "R5");          // expect C5A
    step(4'h3, 2'd1, 1'b0, 1'b0, 1'b1, "R7");          // nibble write, code stays
    step(4'h9, 2'd0, 1'b1, 1'b0, 1'b1, "R6");          // unit not selected
    step(4'h9, 2'd2, 1'b0, 1'b1, 1'b1, "R6");          // strobe high
    step(4'h7, 2'd3, 1'b0, 1'b1, 1'b1, "R6");          // gated transfer
    step(4'hE, 2'd3, 1'b0, 1'b0, 1'b1, "R5");          // expect C3A, data ignored
    step(4'h1, 2'd3, 1'b0, 1'b0, 1'b0, "R8");          // clear beats transfer
    step(4'h0, 2'd3, 1'b0, 1'b0, 1'b1, "R9");          // restores C3A
    step(4'h0, 2'd0, 1'b1, 1'b1, 1'b0, "R8");
    step(4'h0, 2'd3, 1'b0, 1'b0, 1'b1, "R9");
    // random
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] d  = 4'($urandom);
      logic [1:0] s  = 2'($urandom);
      logic       us = ($urandom % 4) == 0;
      logic       w  = ($urandom % 4) == 0;
      logic       cl = ($urandom % 10) != 0;
      string      r;
      if (!cl)                   r = "R8";
      else if (us || w)          r = "R6";
      else if (s == 2'd3)        r = "R5";
      else                       r = "R7";
      step(d, s, us, w, cl, r);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule